// File: doc/BRIEF.md
# Audio Control Register Bank with Staged Update

This block holds the byte-wide control registers of a mixed-signal audio device. A host-side bus adapter writes and reads them through a plain synchronous port made of an address, write data, a write strobe and combinational read data. The active register values drive the device directly. The mute byte and the six channel volume bytes leave the block as parallel outputs.

A freeze bit lets software stage a set of mute and volume changes and then apply them together. While the bit is set, writes to that group land in a pending copy and the outputs keep their old values. When software clears the bit, every pending byte becomes active on the same clock edge. Every other register, including the one that holds the freeze bit, always updates at once.

The block also decodes the pin-control register into pad controls. This covers the interrupt pin's drive style and polarity, the output enable of the serial data output, and the output enables of the serial port 1 bit and frame clocks. The port 1 clock enables depend on whether the port is master or slave.

Top module: `acr_top`

## Requirements
- R1: While the freeze bit is 0, a write to any register address is visible on the matching control output on the clock edge that takes the write.
- R2: While the freeze bit is 1, writes to a staged register leave `mute_o` and `vol_o` unchanged.
- R3: When the freeze bit changes from 1 to 0, all pending staged bytes appear on `mute_o` and `vol_o` on that same edge.
- R4: The staged group is address 0x01, which drives `mute_o`, and addresses 0x0F to 0x14, which drive `vol_o` bytes 0 to 5 in that order (byte k is `vol_o[8k+7:8k]`).
- R5: The pin register at address 0x03 is never staged. Its bit 0 is the freeze bit. A write to it takes effect at once even while frozen, and so does a write to any address outside the staged group.
- R6: A read of a staged address returns the pending value, even while frozen. A read of any other address returns its active value.
- R7: If a staged register is written several times while frozen, the last value written is the one applied on release.
- R8: Pin register bit 1 selects the interrupt drive. At 0 the pin is open-drain active low: `irq_pad_o`=0 and `irq_oe_o` follows `irq_req_i`. At 1 it is push-pull active high: `irq_oe_o`=1 and `irq_pad_o` follows `irq_req_i`.
- R9: Pin register bit 2 set to 1 deasserts `sdout_oe_o`. When the bit is 0, `sdout_oe_o` is 1.
- R10: Pin register bit 4 set to 1 makes port 1 a master. In that case bit 3 set to 1 deasserts `sclk1_oe_o` and `lrck1_oe_o`, and bit 3 set to 0 asserts both. As a slave (bit 4 = 0), both enables are 0 whatever bit 3 holds.
- R11: Reset clears freeze and sets all staged and ordinary registers to 0. The pin register resets to 0x0C, so every output enable is 0 while `irq_req_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| mute_o | output | 8 | Active mute byte |
| vol_o | output | 48 | Active volume bytes, six channels |
| freeze_o | output | 1 | Current freeze bit |
| irq_req_i | input | 1 | Internal interrupt request |
| irq_pad_o | output | 1 | Interrupt pad data |
| irq_oe_o | output | 1 | Interrupt pad output enable |
| sdout_oe_o | output | 1 | Serial data output enable |
| sclk1_oe_o | output | 1 | Port 1 bit clock output enable |
| lrck1_oe_o | output | 1 | Port 1 frame clock output enable |

## Verification
The staging function is exercised by unfrozen writes, by a frozen window with repeated writes to the same byte, by writes to ordinary registers inside that window, and by the release write itself. Together these separate an immediate path, a held path, a partial commit and a first-write-wins error. Long random runs mix pin-register writes that toggle freeze at arbitrary points with random addresses. This catches commits that fire on the wrong edge or leak into non-staged bytes. The pad decode is swept over every combination of the four control bits with the interrupt request both high and low, which separates the master and slave cases and the two interrupt drive styles.

// File: rtl/acr_pkg.sv
package acr_pkg;
    localparam int DW_DEF      = 8;
    localparam int NREG_DEF    = 32;
    localparam int NVOL        = 6;
    localparam int NSTG        = NVOL + 1;
    localparam int MUTE_ADDR   = 'h01;
    localparam int VOL_BASE    = 'h0F;
    localparam int PIN_ADDR    = 'h03;
    localparam int PIN_BITS    = 5;
    localparam int PB_FREEZE   = 0;
    localparam int PB_IRQ_HIGH = 1;
    localparam int PB_SDO_HIZ  = 2;
    localparam int PB_SP1_HIZ  = 3;
    localparam int PB_SP1_MSTR = 4;
    localparam logic [7:0] PIN_RESET = 8'h0C;

    // staged slot of an address, -1 when the address is not staged
    function automatic int stg_slot(int a);
        if (a == MUTE_ADDR) return 0;
        if (a >= VOL_BASE && a < VOL_BASE + NVOL) return a - VOL_BASE + 1;
        return -1;
    endfunction

    function automatic int stg_addr(int s);
        return (s == 0) ? MUTE_ADDR : VOL_BASE + s - 1;
    endfunction
endpackage

// File: rtl/acr_regfile.sv
module acr_regfile
    import acr_pkg::*;
#(
    parameter int DW   = DW_DEF,
    parameter int NREG = NREG_DEF,
    localparam int AW  = $clog2(NREG),
    localparam int SW  = $clog2(NSTG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [DW-1:0]        wdata_i,
    output logic [DW-1:0]        rdata_o,
    output logic [DW-1:0]        mute_o,
    output logic [NVOL*DW-1:0]   vol_o,
    output logic [PIN_BITS-1:0]  pin_cfg_o
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] act;
        logic [NSTG-1:0][DW-1:0] stg;
    } state_t;

    state_t st_d, st_q;
    int     wslot;
    int     rslot;

    always_comb begin
        st_d  = st_q;
        wslot = stg_slot(int'(addr_i));
        if (we_i) begin
            if (wslot >= 0) st_d.stg[SW'(wslot)] = wdata_i;
            else            st_d.act[addr_i]     = wdata_i;
        end
        // staged bytes track their pending copy whenever freeze is clear
        if (!st_d.act[PIN_ADDR][PB_FREEZE]) begin
            for (int s = 0; s < NSTG; s++) begin
                st_d.act[AW'(stg_addr(s))] = st_d.stg[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q               <= '0;
            st_q.act[PIN_ADDR] <= DW'(PIN_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rslot   = stg_slot(int'(addr_i));
        rdata_o = (rslot >= 0) ? st_q.stg[SW'(rslot)] : st_q.act[addr_i];
    end

    assign mute_o    = st_q.act[MUTE_ADDR];
    assign pin_cfg_o = st_q.act[PIN_ADDR][PIN_BITS-1:0];

    for (genvar v = 0; v < NVOL; v++) begin : g_vol
        assign vol_o[v*DW +: DW] = st_q.act[VOL_BASE + v];
    end
endmodule

// File: rtl/acr_pin_decode.sv
module acr_pin_decode
    import acr_pkg::*;
(
    input  logic [PIN_BITS-1:0] cfg_i,
    input  logic                irq_req_i,
    output logic                irq_pad_o,
    output logic                irq_oe_o,
    output logic                sdout_oe_o,
    output logic                sclk1_oe_o,
    output logic                lrck1_oe_o
);
    logic irq_high;
    logic clk1_drive;

    always_comb begin
        irq_high   = cfg_i[PB_IRQ_HIGH];
        // open drain: data fixed low, enable carries the request
        irq_pad_o  = irq_high ? irq_req_i : 1'b0;
        irq_oe_o   = irq_high ? 1'b1 : irq_req_i;
        sdout_oe_o = !cfg_i[PB_SDO_HIZ];
        clk1_drive = cfg_i[PB_SP1_MSTR] && !cfg_i[PB_SP1_HIZ];
        sclk1_oe_o = clk1_drive;
        lrck1_oe_o = clk1_drive;
    end

    logic unused_freeze;
    assign unused_freeze = cfg_i[PB_FREEZE];
endmodule

// File: rtl/acr_top.sv
module acr_top
    import acr_pkg::*;
#(
    parameter int DW   = DW_DEF,
    parameter int NREG = NREG_DEF,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [DW-1:0]       wdata_i,
    output logic [DW-1:0]       rdata_o,
    output logic [DW-1:0]       mute_o,
    output logic [NVOL*DW-1:0]  vol_o,
    output logic                freeze_o,
    input  logic                irq_req_i,
    output logic                irq_pad_o,
    output logic                irq_oe_o,
    output logic                sdout_oe_o,
    output logic                sclk1_oe_o,
    output logic                lrck1_oe_o
);
    logic [PIN_BITS-1:0] pin_cfg;

    acr_regfile #(.DW(DW), .NREG(NREG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .mute_o    (mute_o),
        .vol_o     (vol_o),
        .pin_cfg_o (pin_cfg)
    );

    acr_pin_decode u_pins (
        .cfg_i      (pin_cfg),
        .irq_req_i  (irq_req_i),
        .irq_pad_o  (irq_pad_o),
        .irq_oe_o   (irq_oe_o),
        .sdout_oe_o (sdout_oe_o),
        .sclk1_oe_o (sclk1_oe_o),
        .lrck1_oe_o (lrck1_oe_o)
    );

    assign freeze_o = pin_cfg[PB_FREEZE];
endmodule

// File: rtl/acr_checker.sv
module acr_checker
    import acr_pkg::*;
#(
    parameter int DW = DW_DEF,
    parameter int AW = $clog2(NREG_DEF)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                we_i,
    input logic [AW-1:0]       addr_i,
    input logic [DW-1:0]       wdata_i,
    input logic [DW-1:0]       rdata_o,
    input logic [DW-1:0]       mute_o,
    input logic                freeze_o,
    input logic [PIN_BITS-1:0] pin_cfg,
    input logic                irq_pad_o,
    input logic                irq_oe_o,
    input logic                sdout_oe_o,
    input logic                sclk1_oe_o,
    input logic                lrck1_oe_o
);
    logic mute_hit, pin_hit;
    assign mute_hit = (int'(addr_i) == MUTE_ADDR);
    assign pin_hit  = (int'(addr_i) == PIN_ADDR);

    assert_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_o && we_i && mute_hit) |=> (mute_o == $past(wdata_i)));

    assert_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_o && we_i && mute_hit) |=> $stable(mute_o));

    assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_o && mute_hit) |-> (rdata_o == mute_o));

    assert_pin_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && pin_hit) |=> (freeze_o == $past(wdata_i[PB_FREEZE])));

    assert_irq_od_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_cfg[PB_IRQ_HIGH] |-> !irq_pad_o);

    assert_irq_pp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cfg[PB_IRQ_HIGH] |-> irq_oe_o);

    assert_sdout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pin_cfg[PB_SDO_HIZ] |-> !sdout_oe_o);

    assert_slave_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_cfg[PB_SP1_MSTR] |-> (!sclk1_oe_o && !lrck1_oe_o));
endmodule

bind acr_top acr_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .mute_o     (mute_o),
    .freeze_o   (freeze_o),
    .pin_cfg    (pin_cfg),
    .irq_pad_o  (irq_pad_o),
    .irq_oe_o   (irq_oe_o),
    .sdout_oe_o (sdout_oe_o),
    .sclk1_oe_o (sclk1_oe_o),
    .lrck1_oe_o (lrck1_oe_o)
);

// File: tb/acr_top_bench.sv
module acr_top_bench;
    import acr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_i = 1'b0;
    logic [4:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o, mute_o;
    logic [47:0] vol_o;
    logic        freeze_o, irq_req_i = 1'b0;
    logic        irq_pad_o, irq_oe_o, sdout_oe_o, sclk1_oe_o, lrck1_oe_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] m_act [32];
    logic [7:0] m_stg [7];

    always #5 clk = ~clk;

    acr_top u_acr_top (.*);

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) m_act[i] = 8'h00;
        for (int s = 0; s < 7; s++) m_stg[s] = 8'h00;
        m_act[PIN_ADDR] = PIN_RESET;
    endtask

    task automatic model_write(int a, logic [7:0] d);
        int s = stg_slot(a);
        if (s >= 0) m_stg[s] = d; else m_act[a] = d;
        if (!m_act[PIN_ADDR][0])
            for (int k = 0; k < 7; k++) m_act[stg_addr(k)] = m_stg[k];
    endtask

    task automatic check_outs(string req);
        logic [7:0] p = m_act[PIN_ADDR];
        chk(mute_o == m_act[MUTE_ADDR], req, mute_o, m_act[MUTE_ADDR]);
        for (int v = 0; v < 6; v++)
            chk(vol_o[v*8 +: 8] == m_act[VOL_BASE+v], req, vol_o[v*8 +: 8], m_act[VOL_BASE+v]);
        chk(freeze_o == p[0], req, freeze_o, p[0]);
        chk(irq_oe_o == (p[1] ? 1'b1 : irq_req_i), {req, " R8"}, irq_oe_o, p[1] ? 1'b1 : irq_req_i);
        chk(irq_pad_o == (p[1] ? irq_req_i : 1'b0), {req, " R8"}, irq_pad_o, p[1] ? irq_req_i : 1'b0);
        chk(sdout_oe_o == !p[2], {req, " R9"}, sdout_oe_o, !p[2]);
        chk(sclk1_oe_o == (p[4] && !p[3]), {req, " R10"}, sclk1_oe_o, p[4] && !p[3]);
        chk(lrck1_oe_o == (p[4] && !p[3]), {req, " R10"}, lrck1_oe_o, p[4] && !p[3]);
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        we_i = 1'b1; addr_i = 5'(a); wdata_i = d;
        @(negedge clk);
        we_i = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(int a, string req);
        logic [7:0] e;
        int s = stg_slot(a);
        @(negedge clk);
        addr_i = 5'(a);
        #1;
        e = (s >= 0) ? m_stg[s] : m_act[a];
        chk(rdata_o == e, req, rdata_o, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check_outs("R11");
        chk(sdout_oe_o == 1'b0 && sclk1_oe_o == 1'b0 && irq_oe_o == 1'b0, "R11", 0, 0);
        rd(PIN_ADDR, "R11");

        // R1 immediate writes, R4 byte order
        wr(MUTE_ADDR, 8'hA5);
        check_outs("R1");
        for (int v = 0; v < 6; v++) wr(VOL_BASE + v, 8'(8'h10 + v));
        check_outs("R4");

        // frozen window: R2, R5, R6, R7
        wr(PIN_ADDR, 8'h0D);
        wr(MUTE_ADDR, 8'h11);
        wr(MUTE_ADDR, 8'h22);
        wr(MUTE_ADDR, 8'h33);
        for (int v = 0; v < 6; v++) wr(VOL_BASE + v, 8'(8'hC0 + v));
        check_outs("R2");
        chk(mute_o == 8'hA5, "R2", mute_o, 8'hA5);
        rd(MUTE_ADDR, "R6");
        rd(VOL_BASE + 5, "R6");
        wr(8'h05, 8'h77);
        rd(8'h05, "R5");
        wr(PIN_ADDR, 8'h1D);
        check_outs("R5");
        // release: R3, R7
        wr(PIN_ADDR, 8'h0C);
        check_outs("R3");
        chk(mute_o == 8'h33, "R7", mute_o, 8'h33);
        chk(vol_o[47:40] == 8'hC5, "R3", vol_o[47:40], 8'hC5);

        // pad decode sweep: R8 R9 R10
        for (int c = 0; c < 16; c++) begin
            for (int q = 0; q < 2; q++) begin
                wr(PIN_ADDR, 8'(c << 1));
                irq_req_i = q[0];
                #1;
                check_outs("R8");
            end
        end

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int a;
            case ($urandom % 4)
                0: a = MUTE_ADDR;
                1: a = VOL_BASE + int'($urandom % 6);
                2: a = PIN_ADDR;
                default: a = int'($urandom % 32);
            endcase
            irq_req_i = 1'($urandom);
            wr(a, 8'($urandom));
            check_outs("R1");
            rd(int'($urandom % 32), "R6");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule